// File: doc/BRIEF.md
# SD Command Issue and Response Capture Unit

This block is the command half of an SD host controller, seen from software as a small register file. Software loads a 32-bit argument and then writes a 16-bit command word. When bit 15 of that word is set, the block sends the 6-bit command index and the argument to the card side as a single-cycle request. It then waits for the card side to return a reply strobe. The strobe carries an error flag, a byte count and a 16-byte buffer.

The block compares the reply length with the response kind that the command word asked for: none, short (4 bytes) or long (16 bytes). A good reply is packed big-endian into four read-only 32-bit response words. A long reply goes into them in reversed word order. A bad reply, or an error reported by the card side, sets a fail flag in the command word and a timeout bit in a status register. Software clears that status bit by writing a one to it.

Top module: `sdc_cmd_unit`

## Requirements
- R1: After reset, the command word, argument, status register and all four response words read as zero, and `card_req` is low.
- R2: Writing the command word (offset 0x00) with bit 15 set raises `card_req` for exactly one cycle, in the cycle after the write. Bit 15 reads back as 1 until the reply strobe arrives and as 0 afterwards. Writes to the command word while bit 15 is set are ignored.
- R3: At the request, `card_cmd_idx` carries bits 5:0 of the command word and `card_arg` carries the argument register (offset 0x04).
- R4: A reply strobe with `card_rsp_err` high sets bit 14 of the command word and bit 6 of the status register (offset 0x20), whatever the response kind. The response words are left unchanged.
- R5: When a response is expected (bit 10 clear), the reply fails in the same way as in R4 if the length is anything other than 4 or 16, or if it is 4 while the long flag (bit 9) is set. The response words are left unchanged.
- R6: A good 4-byte reply loads response word 0 (offset 0x10) with byte 0 in bits 31:24, down to byte 3 in bits 7:0. Words 1 to 3 are cleared. Byte i of the reply is `card_rsp_bytes[8i+7:8i]`.
- R7: A good 16-byte reply loads word k (offset 0x10+4k) with bytes 12-4k to 15-4k, packed big-endian. So word 0 holds bytes 12 to 15 and word 3 holds bytes 0 to 3.
- R8: With the no-response flag (bit 10) set, the length is not checked and the response words stay unchanged. Only a card-side error fails the command.
- R9: Reads return data one cycle after `rd_en`. The response words ignore writes. Unmapped offsets read as zero.
- R10: Writing the status register clears each status bit whose written bit is 1 and leaves the other bits alone.
- R11: A reply strobe while no command is pending changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | DATA_W | Read data, one cycle after rd_en |
| card_req | output | 1 | One-cycle command request to the card side |
| card_cmd_idx | output | 6 | Command index sent with the request |
| card_arg | output | DATA_W | Argument sent with the request |
| card_rsp_valid | input | 1 | Reply strobe from the card side |
| card_rsp_err | input | 1 | Card side reports a failed exchange |
| card_rsp_len | input | LEN_W | Reply length in bytes |
| card_rsp_bytes | input | 8*RSP_BYTES | Reply bytes, byte i at bits 8i+7:8i |

## Verification
The hardest states to reach from the ports are the failures that depend on both the length and the flags. One is a 4-byte reply to a long command. Another is an odd length on a short command, which must fail. The same lengths on a no-response command must pass without touching the response words. The stimulus therefore first loads known long and short values into the response words. It then sends each bad length under each flag combination and reads every word back, so that a partial load is caught. A stray reply strobe with no command pending, and a command write made while a request is still outstanding, are also driven on purpose.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  // command word field positions (software-visible encoding)
  localparam int CMD_W      = 16;
  localparam int IDX_W      = 6;
  localparam int BIT_NEW    = 15;
  localparam int BIT_FAIL   = 14;
  localparam int BIT_NORSP  = 10;
  localparam int BIT_LONG   = 9;
  // status register
  localparam int STAT_W     = 11;
  localparam int STAT_TMO   = 6;
  // byte offsets
  localparam int OFS_CMD    = 'h00;
  localparam int OFS_ARG    = 'h04;
  localparam int OFS_RSP0   = 'h10;
  localparam int OFS_STAT   = 'h20;
  // reply lengths
  localparam int SHORT_LEN  = 4;
endpackage

// File: rtl/sdc_rsp_check.sv
module sdc_rsp_check #(
  parameter int DATA_W    = 32,
  parameter int RSP_BYTES = 16,
  parameter int LEN_W     = 5,
  localparam int WB       = DATA_W / 8,
  localparam int NWORDS   = RSP_BYTES / WB
) (
  input  logic                   no_rsp,
  input  logic                   long_rsp,
  input  logic                   card_err,
  input  logic [LEN_W-1:0]       len,
  input  logic [8*RSP_BYTES-1:0] bytes_in,
  output logic                   fail,
  output logic                   load,
  output logic [DATA_W-1:0]      words [NWORDS]
);
  logic [DATA_W-1:0] long_w [NWORDS];
  logic is_short, is_long, len_bad;

  // word k takes the byte group counted from the end of the buffer
  for (genvar k = 0; k < NWORDS; k++) begin : g_word
    for (genvar j = 0; j < WB; j++) begin : g_byte
      assign long_w[k][DATA_W-1-8*j -: 8] = bytes_in[8*((NWORDS-1-k)*WB+j) +: 8];
    end
  end

  assign is_short = (len == LEN_W'(sdc_pkg::SHORT_LEN));
  assign is_long  = (len == LEN_W'(RSP_BYTES));
  assign len_bad  = !(is_short || is_long) || (is_short && long_rsp);
  assign fail     = card_err || (!no_rsp && len_bad);
  assign load     = !no_rsp && !fail;

  for (genvar k = 0; k < NWORDS; k++) begin : g_sel
    if (k == 0) begin : g_first
      assign words[k] = is_long ? long_w[k] : long_w[NWORDS-1];
    end else begin : g_rest
      assign words[k] = is_long ? long_w[k] : '0;
    end
  end
endmodule

// File: rtl/sdc_rsp_store.sv
module sdc_rsp_store #(
  parameter int DATA_W = 32,
  parameter int NWORDS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] words_in [NWORDS],
  output logic [DATA_W-1:0] words_q  [NWORDS]
);
  for (genvar k = 0; k < NWORDS; k++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)       words_q[k] <= '0;
      else if (load) words_q[k] <= words_in[k];
    end
  end
endmodule

// File: rtl/sdc_cmd_ctrl.sv
module sdc_cmd_ctrl
  import sdc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic [CMD_W-1:0]  cmd_wdata,
  input  logic [DATA_W-1:0] arg_q,
  input  logic              rsp_take,
  input  logic              rsp_fail,
  output logic [CMD_W-1:0]  cmd_q,
  output logic              card_req,
  output logic [IDX_W-1:0]  card_idx,
  output logic [DATA_W-1:0] card_arg
);
  logic pending;
  assign pending = cmd_q[BIT_NEW];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= '0;
      card_req <= 1'b0;
      card_idx <= '0;
      card_arg <= '0;
    end else begin
      card_req <= 1'b0;
      if (cmd_we && !pending) begin
        cmd_q <= cmd_wdata;
        if (cmd_wdata[BIT_NEW]) begin
          card_req <= 1'b1;
          card_idx <= cmd_wdata[IDX_W-1:0];
          card_arg <= arg_q;
        end
      end else if (rsp_take) begin
        cmd_q[BIT_NEW] <= 1'b0;
        if (rsp_fail) cmd_q[BIT_FAIL] <= 1'b1;
      end
    end
  end

  AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    card_req |=> !card_req); // R2
  AST_REQ_WHILE_PENDING: assert property (@(posedge clk) disable iff (rst)
    card_req |-> pending); // R2
  AST_DONE_CLEARS_NEW: assert property (@(posedge clk) disable iff (rst)
    rsp_take |=> !pending); // R2
  AST_FAIL_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    (rsp_take && rsp_fail) |=> cmd_q[BIT_FAIL]); // R4
  AST_PENDING_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (pending && !rsp_take) |=> $stable(cmd_q)); // R2
endmodule

// File: rtl/sdc_cmd_unit.sv
module sdc_cmd_unit
  import sdc_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int RSP_BYTES = 16,
  parameter int LEN_W     = 5,
  localparam int NWORDS   = RSP_BYTES / (DATA_W / 8)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [DATA_W-1:0]      rd_data,
  output logic                   card_req,
  output logic [5:0]             card_cmd_idx,
  output logic [DATA_W-1:0]      card_arg,
  input  logic                   card_rsp_valid,
  input  logic                   card_rsp_err,
  input  logic [LEN_W-1:0]       card_rsp_len,
  input  logic [8*RSP_BYTES-1:0] card_rsp_bytes
);
  logic [CMD_W-1:0]  cmd_q;
  logic [DATA_W-1:0] arg_q;
  logic [STAT_W-1:0] stat_q, stat_nxt;
  logic              rsp_take, chk_fail, chk_load;
  logic [DATA_W-1:0] chk_words [NWORDS];
  logic [DATA_W-1:0] rsp_q     [NWORDS];
  logic [DATA_W-1:0] rd_mux;

  assign rsp_take = card_rsp_valid && cmd_q[BIT_NEW];

  sdc_cmd_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .cmd_we    (wr_en && wr_addr == ADDR_W'(OFS_CMD)),
    .cmd_wdata (wr_data[CMD_W-1:0]),
    .arg_q     (arg_q),
    .rsp_take  (rsp_take),
    .rsp_fail  (chk_fail),
    .cmd_q     (cmd_q),
    .card_req  (card_req),
    .card_idx  (card_cmd_idx),
    .card_arg  (card_arg)
  );

  sdc_rsp_check #(.DATA_W(DATA_W), .RSP_BYTES(RSP_BYTES), .LEN_W(LEN_W)) check_i (
    .no_rsp   (cmd_q[BIT_NORSP]),
    .long_rsp (cmd_q[BIT_LONG]),
    .card_err (card_rsp_err),
    .len      (card_rsp_len),
    .bytes_in (card_rsp_bytes),
    .fail     (chk_fail),
    .load     (chk_load),
    .words    (chk_words)
  );

  sdc_rsp_store #(.DATA_W(DATA_W), .NWORDS(NWORDS)) store_i (
    .clk      (clk),
    .rst      (rst),
    .load     (rsp_take && chk_load),
    .words_in (chk_words),
    .words_q  (rsp_q)
  );

  always_ff @(posedge clk) begin
    if (rst)                                         arg_q <= '0;
    else if (wr_en && wr_addr == ADDR_W'(OFS_ARG))   arg_q <= wr_data;
  end

  // a fresh failure wins over a clear in the same cycle
  always_comb begin
    stat_nxt = stat_q;
    if (wr_en && wr_addr == ADDR_W'(OFS_STAT)) stat_nxt = stat_q & ~wr_data[STAT_W-1:0];
    if (rsp_take && chk_fail) stat_nxt[STAT_TMO] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= stat_nxt;
  end

  always_comb begin
    rd_mux = '0;
    if (rd_addr == ADDR_W'(OFS_CMD))  rd_mux = DATA_W'(cmd_q);
    if (rd_addr == ADDR_W'(OFS_ARG))  rd_mux = arg_q;
    if (rd_addr == ADDR_W'(OFS_STAT)) rd_mux = DATA_W'(stat_q);
    for (int k = 0; k < NWORDS; k++) begin
      if (rd_addr == ADDR_W'(OFS_RSP0 + 4*k)) rd_mux = rsp_q[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  AST_TMO_ON_FAIL: assert property (@(posedge clk) disable iff (rst)
    (rsp_take && chk_fail) |=> stat_q[STAT_TMO]); // R4
  AST_NORSP_KEEPS_WORDS: assert property (@(posedge clk) disable iff (rst)
    (rsp_take && cmd_q[BIT_NORSP]) |=> $stable(rsp_q[0]) && $stable(rsp_q[NWORDS-1])); // R8
  AST_STRAY_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (card_rsp_valid && !cmd_q[BIT_NEW] && !wr_en) |=> $stable(rsp_q[0]) && $stable(stat_q)); // R11
  AST_FAIL_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    (rsp_take && chk_fail) |=> $stable(rsp_q[0])); // R5
endmodule

// File: tb/sdc_cmd_unit_tb_top.sv
`timescale 1ns/1ps
module sdc_cmd_unit_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic card_req;
  logic [5:0] card_cmd_idx;
  logic [31:0] card_arg;
  logic card_rsp_valid = 1'b0, card_rsp_err = 1'b0;
  logic [4:0] card_rsp_len = '0;
  logic [127:0] card_rsp_bytes = '0;

  always #2.5 clk = ~clk;

  sdc_cmd_unit dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .card_req(card_req), .card_cmd_idx(card_cmd_idx), .card_arg(card_arg),
    .card_rsp_valid(card_rsp_valid), .card_rsp_err(card_rsp_err),
    .card_rsp_len(card_rsp_len), .card_rsp_bytes(card_rsp_bytes)
  );

  int checks = 0, fails = 0;
  bit running = 0, done = 0;
  // reference model state
  logic [15:0] m_cmd = '0;
  logic [31:0] m_arg = '0;
  logic [10:0] m_stat = '0;
  logic [31:0] m_rsp [4] = '{default: '0};
  bit req_due = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every clock: request pulse must match the model (R2)
  always @(negedge clk) begin
    if (running) begin
      chk("R2 card_req per cycle", {31'b0, card_req}, {31'b0, req_due});
      req_due = 0;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1 wr_en = 0;
    case (a)
      8'h00: if (!m_cmd[15]) begin m_cmd = d[15:0]; if (d[15]) req_due = 1; end
      8'h04: m_arg = d;
      8'h20: m_stat = m_stat & ~d[10:0];
      default: ;
    endcase
  endtask

  task automatic rdchk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(posedge clk);
    @(negedge clk); rd_en = 0;
    chk(tag, rd_data, exp);
  endtask

  task automatic check_all(input string tag);
    rdchk(8'h00, {16'b0, m_cmd}, {tag, " cmd"});
    rdchk(8'h20, {21'b0, m_stat}, {tag, " status"});
    for (int k = 0; k < 4; k++) rdchk(8'(8'h10 + 4*k), m_rsp[k], {tag, " rsp"});
  endtask

  function automatic logic [7:0] bget(input logic [127:0] v, input int i);
    return v[8*i +: 8];
  endfunction

  task automatic respond(input bit err, input int len, input logic [127:0] bv);
    bit nr, lg, bad;
    @(negedge clk);
    card_rsp_valid = 1; card_rsp_err = err; card_rsp_len = 5'(len); card_rsp_bytes = bv;
    @(posedge clk); #1 card_rsp_valid = 0; card_rsp_err = 0;
    if (m_cmd[15]) begin
      nr = m_cmd[10]; lg = m_cmd[9];
      bad = err || (!nr && !((len == 4 && !lg) || len == 16));
      m_cmd[15] = 0;
      if (bad) begin m_cmd[14] = 1; m_stat[6] = 1; end
      else if (!nr) begin
        if (len == 16) begin
          for (int k = 0; k < 4; k++)
            m_rsp[k] = {bget(bv, 12-4*k), bget(bv, 13-4*k), bget(bv, 14-4*k), bget(bv, 15-4*k)};
        end else begin
          m_rsp[0] = {bget(bv, 0), bget(bv, 1), bget(bv, 2), bget(bv, 3)};
          m_rsp[1] = 0; m_rsp[2] = 0; m_rsp[3] = 0;
        end
      end
    end
  endtask

  function automatic logic [127:0] pat(input logic [7:0] base);
    logic [127:0] v;
    for (int i = 0; i < 16; i++) v[8*i +: 8] = base + 8'(i * 17);
    return v;
  endfunction

  task automatic issue(input logic [15:0] c, input string tag);
    wr(8'h00, {16'b0, c});
    @(negedge clk);
    chk({tag, " R3 idx"}, {26'b0, card_cmd_idx}, {26'b0, c[5:0]});
    chk({tag, " R3 arg"}, card_arg, m_arg);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    running = 1;
    check_all("R1 reset");

    // long command with 16-byte reply
    wr(8'h04, 32'hDEADBEEF);
    rdchk(8'h04, 32'hDEADBEEF, "R9 arg readback");
    issue(16'h8211, "long");
    rdchk(8'h00, {16'b0, m_cmd}, "R2 new bit held while pending");
    wr(8'h00, 32'h0000_8005);                 // ignored while pending
    rdchk(8'h00, 32'h0000_8211, "R2 write ignored while pending");
    respond(0, 16, pat(8'h01));
    check_all("R7 long reply");

    // short reply
    wr(8'h04, 32'h1234_5678);
    issue(16'h800D, "short");
    respond(0, 4, pat(8'h40));
    check_all("R6 short reply");

    // reload long values so a partial write is visible
    issue(16'h8202, "reload");
    respond(0, 16, pat(8'h90));
    check_all("R7 second long reply");

    // 4 bytes to a long command fails
    issue(16'h8203, "long4");
    respond(0, 4, pat(8'h22));
    check_all("R5 short length on long command");

    // clear status (write-one-to-clear), write of zero clears nothing
    wr(8'h20, 32'h0);
    rdchk(8'h20, 32'h40, "R10 zero write keeps status");
    wr(8'h20, 32'h40);
    rdchk(8'h20, 32'h0, "R10 one clears status");

    // odd length on short command fails
    issue(16'h8004, "len7");
    respond(0, 7, pat(8'h33));
    check_all("R5 odd length");
    wr(8'h20, 32'h7FF);
    issue(16'h8006, "len0");
    respond(0, 0, pat(8'h35));
    check_all("R5 zero length");

    // card error on a no-response command
    wr(8'h20, 32'h7FF);
    issue(16'h8407, "err");
    respond(1, 16, pat(8'h55));
    check_all("R4 card error");

    // no-response commands: length ignored, words untouched
    wr(8'h20, 32'h7FF);
    issue(16'h8408, "norsp0");
    respond(0, 0, pat(8'h66));
    check_all("R8 no-response length 0");
    issue(16'h8609, "norsp16");
    respond(0, 16, pat(8'h77));
    check_all("R8 no-response length 16");

    // response words ignore writes, unmapped reads zero
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h1C, 32'hFFFF_FFFF);
    check_all("R9 response words read-only");
    rdchk(8'h2C, 32'h0, "R9 unmapped offset");

    // stray reply strobe with nothing pending
    respond(1, 4, pat(8'hA0));
    check_all("R11 stray reply");

    repeat (4) @(negedge clk);
    running = 0;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
    end
    $finish;
  end

  initial begin
    #(5 * 100000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("%0d/%0d checks passed", checks - fails, checks);
    end
    $finish;
  end
endmodule